// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Write-Back Data Cache

This block is a 32 KB data cache with four ways and 32-byte lines (256 sets). A request carries a virtual address. The set is selected from the low virtual address bits, which lie entirely inside the 13-bit page offset, so the tag and data arrays are read while the translation is still being produced. The translated physical page number comes from an external translation buffer in the same cycle as the request. It is registered with the request, and in the following cycle it is compared against the physical tags held in every way of the set. Two virtual pages that map to one physical page therefore land in the same set and match the same stored tag.

Stores merge 32-bit words under byte enables and mark the line dirty. A miss of either kind allocates a line. The victim is the first invalid way, or else the way whose 2-bit age is oldest. A dirty victim goes out on a line-wide memory request, using its stored physical tag, before the refill is requested. The request side and the memory request side are valid/ready streams:

- A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that point until the response.
- A memory request, once raised, holds its valid, address, direction and data until `mem_req_ready` accepts it.
- The response and the memory refill are single-cycle pulses with no back-pressure. The requester and the memory must take them when they appear.

Top module: `vipt_dcache`

## Requirements
- R1: After reset `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0.
- R2: A read miss issues exactly one read memory request to the line address {ppn, vaddr[12:5], 5'b0}. The response returns the word at physical address {ppn, vaddr[12:2], 2'b00}. Later reads of that line cause no memory traffic.
- R3: Hit detection compares stored physical tags with the translated page number. A different virtual page mapped to the same physical page hits without a memory request.
- R4: A request whose page number differs from every valid tag in the set is a miss, even when the virtual address is identical.
- R5: A write hit replaces only the bytes whose `req_be` bit is set (bit b selects data bits 8b+7:8b) and causes no memory traffic.
- R6: A write miss refills the line, merges the write into it, and leaves it resident, so a later read hits.
- R7: Ages within a set are always a permutation of 0..3, and an accessed way becomes age 0. With no invalid way, the victim is the way of age 3, i.e. the least recently used.
- R8: Evicting a dirty line first issues a write memory request to {stored tag, index, 5'b0} carrying the line. The refill read request is issued only after that write is accepted. A clean victim produces no write.
- R9: When `tlb_valid` is 0 with the request, the response has `rsp_abort`=1. No memory request, data change, dirty change or age change results.
- R10: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the memory request address and direction stay unchanged.
- R12: `rsp_valid` is a one-cycle pulse per accepted request. A hit responds two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| tlb_valid | input | 1 | Translation valid, sampled with the request |
| tlb_ppn | input | 19 | Physical page number, sampled with the request |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Loaded word (merged word for stores) |
| rsp_abort | output | 1 | Access aborted for lack of a translation |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned physical address |
| mem_req_wdata | output | 256 | Line being written back |
| mem_rsp_valid | input | 1 | Refill data pulse |
| mem_rsp_rdata | input | 256 | Refill line |

## Verification
The lookup is driven with several address patterns:

- A cold read of a line, followed by a neighbouring word. This separates the refill from a true hit.
- The same set index reached from a second virtual page that maps to the same physical page. This separates physical-tag matching from any virtual comparison.
- The identical virtual address with a new page number. This shows that the tag decides the hit, not the index.

Five distinct pages are streamed through one set with a re-touch in between, to tell least-recently-used order apart from fill order. A dirty line is then pushed out to show the write-before-read ordering and the address built from the stored tag. A store without a translation is followed by a read of the same word to show that nothing moved. Memory acceptance is stalled on every request so that the held request is observed.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WBACK,
    ST_FETCH,
    ST_WAIT
  } vipt_state_e;
endpackage

// File: rtl/vipt_way_bank.sv
module vipt_way_bank #(
  parameter int SETS   = 256,
  parameter int TAG_W  = 19,
  parameter int LINE_W = 256,
  parameter int IDX_W  = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_dirty,
  output logic              q_valid,
  output logic              q_dirty,
  output logic [TAG_W-1:0]  q_tag,
  output logic [LINE_W-1:0] q_line
);
  logic [SETS-1:0]   valid_r;
  logic [SETS-1:0]   dirty_r;
  logic [TAG_W-1:0]  tag_r  [SETS];
  logic [LINE_W-1:0] line_r [SETS];

  // state bits: need a defined reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_r <= '0;
      dirty_r <= '0;
    end else if (wr_en) begin
      valid_r[wr_idx] <= 1'b1;
      dirty_r[wr_idx] <= wr_dirty;
    end
  end

  // payload arrays: no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_r[wr_idx]  <= wr_tag;
      line_r[wr_idx] <= wr_line;
    end
  end

  // registered read of the selected set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_dirty <= 1'b0;
    end else if (rd_en) begin
      q_valid <= valid_r[rd_idx];
      q_dirty <= dirty_r[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      q_tag  <= tag_r[rd_idx];
      q_line <= line_r[rd_idx];
    end
  end
endmodule

// File: rtl/vipt_age_lru.sv
module vipt_age_lru #(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  parameter int AW    = $clog2(WAYS),
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [WAYS-1:0][AW-1:0]  q_age,
  input  logic                     upd_en,
  input  logic [IDX_W-1:0]         upd_idx,
  input  logic [AW-1:0]            upd_way
);
  logic [WAYS-1:0][AW-1:0] ages_r [SETS];
  logic [WAYS-1:0][AW-1:0] next_age;
  logic [WAYS-1:0]         seen;

  // accessed way -> 0; younger ways age by one
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (AW'(w) == upd_way)
        next_age[w] = '0;
      else if (q_age[w] < q_age[upd_way])
        next_age[w] = q_age[w] + 1'b1;
      else
        next_age[w] = q_age[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ages_r[s][w] <= AW'(w);
    end else if (upd_en) begin
      ages_r[upd_idx] <= next_age;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++)
        q_age[w] <= AW'(w);
    end else if (rd_en) begin
      q_age <= ages_r[rd_idx];
    end
  end

  always_comb begin
    seen = '0;
    for (int w = 0; w < WAYS; w++)
      seen[q_age[w]] = 1'b1;
  end

  // R7
  age_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) &seen);
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
  import vipt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WAYS   = 4,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 5,
  parameter int TAG_W  = 19,
  parameter int LINE_W = 256,
  parameter int AW     = $clog2(WAYS),
  parameter int BE_W   = WORD_W / 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_vaddr,
  input  logic [WORD_W-1:0]             req_wdata,
  input  logic [BE_W-1:0]               req_be,
  input  logic                          tlb_valid,
  input  logic [TAG_W-1:0]              tlb_ppn,
  output logic                          rsp_valid,
  output logic [WORD_W-1:0]             rsp_rdata,
  output logic                          rsp_abort,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic                          mem_req_write,
  output logic [ADDR_W-1:0]             mem_req_addr,
  output logic [LINE_W-1:0]             mem_req_wdata,
  input  logic                          mem_rsp_valid,
  input  logic [LINE_W-1:0]             mem_rsp_rdata,
  output logic                          rd_en,
  output logic [IDX_W-1:0]              rd_idx,
  input  logic [WAYS-1:0]               way_valid,
  input  logic [WAYS-1:0]               way_dirty,
  input  logic [WAYS-1:0][TAG_W-1:0]    way_tag,
  input  logic [WAYS-1:0][LINE_W-1:0]   way_line,
  output logic [WAYS-1:0]               wr_en,
  output logic [IDX_W-1:0]              wr_idx,
  output logic [TAG_W-1:0]              wr_tag,
  output logic [LINE_W-1:0]             wr_line,
  output logic                          wr_dirty,
  input  logic [WAYS-1:0][AW-1:0]       age_q,
  output logic                          upd_en,
  output logic [AW-1:0]                 upd_way
);
  localparam int WPL    = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WPL);
  localparam int BSEL_W = $clog2(BE_W);

  vipt_state_e         st, st_n;
  logic                write_q, tlbok_q;
  logic [ADDR_W-1:0]   vaddr_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [BE_W-1:0]     be_q;
  logic [TAG_W-1:0]    ppn_q;
  logic [AW-1:0]       victim_q;

  logic [WAYS-1:0]     hit_vec;
  logic                hit_any;
  logic [AW-1:0]       hit_way, vict;
  logic                free_found;
  logic [IDX_W-1:0]    idx_q;
  logic [WSEL_W-1:0]   wsel_q;
  logic                rsp_set, abort_set;
  logic [WORD_W-1:0]   rsp_word;

  function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] line,
                                                   input logic [WSEL_W-1:0] sel,
                                                   input logic [WORD_W-1:0] d,
                                                   input logic [BE_W-1:0] be);
    logic [LINE_W-1:0] r;
    r = line;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[int'(sel) * WORD_W + b * 8 +: 8] = d[b * 8 +: 8];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [WSEL_W-1:0] sel);
    return line[int'(sel) * WORD_W +: WORD_W];
  endfunction

  assign idx_q     = vaddr_q[OFF_W +: IDX_W];
  assign wsel_q    = vaddr_q[BSEL_W +: WSEL_W];
  assign req_ready = (st == ST_IDLE);
  assign rd_en     = req_valid && req_ready;
  assign rd_idx    = req_vaddr[OFF_W +: IDX_W];
  assign wr_idx    = idx_q;
  assign wr_tag    = ppn_q;

  // physical tag compare and victim choice
  always_comb begin
    hit_vec    = '0;
    hit_way    = '0;
    vict       = '0;
    free_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = way_valid[w] && (way_tag[w] == ppn_q);
      if (hit_vec[w]) hit_way = AW'(w);
    end
    for (int w = 0; w < WAYS; w++)
      if (!way_valid[w] && !free_found) begin
        vict       = AW'(w);
        free_found = 1'b1;
      end
    if (!free_found)
      for (int w = 0; w < WAYS; w++)
        if (age_q[w] == AW'(WAYS - 1)) vict = AW'(w);
  end
  assign hit_any = |hit_vec;

  always_comb begin
    st_n          = st;
    wr_en         = '0;
    wr_line       = '0;
    wr_dirty      = 1'b0;
    upd_en        = 1'b0;
    upd_way       = hit_way;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = {ppn_q, idx_q, {OFF_W{1'b0}}};
    mem_req_wdata = way_line[victim_q];
    rsp_set       = 1'b0;
    abort_set     = 1'b0;
    rsp_word      = '0;
    unique case (st)
      ST_IDLE: if (rd_en) st_n = ST_LOOK;
      ST_LOOK: begin
        if (!tlbok_q) begin
          rsp_set   = 1'b1;
          abort_set = 1'b1;
          st_n      = ST_IDLE;
        end else if (hit_any) begin
          wr_line  = merge_word(way_line[hit_way], wsel_q, wdata_q, be_q);
          wr_dirty = 1'b1;
          wr_en[hit_way] = write_q;
          upd_en   = 1'b1;
          rsp_set  = 1'b1;
          rsp_word = write_q ? pick_word(wr_line, wsel_q) : pick_word(way_line[hit_way], wsel_q);
          st_n     = ST_IDLE;
        end else begin
          st_n = (way_valid[vict] && way_dirty[vict]) ? ST_WBACK : ST_FETCH;
        end
      end
      ST_WBACK: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = {way_tag[victim_q], idx_q, {OFF_W{1'b0}}};
        if (mem_req_ready) st_n = ST_FETCH;
      end
      ST_FETCH: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          wr_line  = write_q ? merge_word(mem_rsp_rdata, wsel_q, wdata_q, be_q) : mem_rsp_rdata;
          wr_dirty = write_q;
          wr_en[victim_q] = 1'b1;
          upd_en   = 1'b1;
          upd_way  = victim_q;
          rsp_set  = 1'b1;
          rsp_word = pick_word(wr_line, wsel_q);
          st_n     = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      write_q   <= 1'b0;
      tlbok_q   <= 1'b0;
      vaddr_q   <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      ppn_q     <= '0;
      victim_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_abort <= 1'b0;
    end else begin
      st        <= st_n;
      rsp_valid <= rsp_set;
      if (rd_en) begin
        write_q <= req_write;
        tlbok_q <= tlb_valid;
        vaddr_q <= req_vaddr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        ppn_q   <= tlb_ppn;
      end
      if (st == ST_LOOK && tlbok_q && !hit_any) victim_q <= vict;
      if (rsp_set) begin
        rsp_rdata <= rsp_word;
        rsp_abort <= abort_set;
      end
    end
  end

  // R3
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOOK) |-> $onehot0(hit_vec));
  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=> (mem_req_valid && !mem_req_write));
  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOOK && !tlbok_q) |=> (rsp_valid && rsp_abort && !mem_req_valid));
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2
  refill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && mem_rsp_valid) |=> (rsp_valid && !rsp_abort));
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 256,
  parameter int LINE_BYTES = 32,
  parameter int OFF_W      = $clog2(LINE_BYTES),
  parameter int IDX_W      = $clog2(SETS),
  parameter int TAG_W      = ADDR_W - OFF_W - IDX_W,
  parameter int LINE_W     = LINE_BYTES * 8,
  parameter int BE_W       = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              tlb_valid,
  input  logic [TAG_W-1:0]  tlb_ppn,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_abort,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_rdata
);
  localparam int AW = $clog2(WAYS);

  logic                         rd_en;
  logic [IDX_W-1:0]             rd_idx, wr_idx;
  logic [WAYS-1:0]              way_valid, way_dirty, wr_en;
  logic [WAYS-1:0][TAG_W-1:0]   way_tag;
  logic [WAYS-1:0][LINE_W-1:0]  way_line;
  logic [TAG_W-1:0]             wr_tag;
  logic [LINE_W-1:0]            wr_line;
  logic                         wr_dirty, upd_en;
  logic [WAYS-1:0][AW-1:0]      age_q;
  logic [AW-1:0]                upd_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vipt_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_idx(rd_idx),
      .wr_en(wr_en[w]), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_line(wr_line), .wr_dirty(wr_dirty),
      .q_valid(way_valid[w]), .q_dirty(way_dirty[w]), .q_tag(way_tag[w]), .q_line(way_line[w])
    );
  end

  vipt_age_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_idx(rd_idx), .q_age(age_q),
    .upd_en(upd_en), .upd_idx(wr_idx), .upd_way(upd_way)
  );

  vipt_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WAYS(WAYS), .IDX_W(IDX_W),
    .OFF_W(OFF_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata), .req_be(req_be),
    .tlb_valid(tlb_valid), .tlb_ppn(tlb_ppn),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .way_valid(way_valid), .way_dirty(way_dirty), .way_tag(way_tag), .way_line(way_line),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_line(wr_line), .wr_dirty(wr_dirty),
    .age_q(age_q), .upd_en(upd_en), .upd_way(upd_way)
  );

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/vipt_dcache_test.sv
module vipt_dcache_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, tlb_valid = 1'b0;
  logic [31:0]  req_vaddr = '0, req_wdata = '0;
  logic [3:0]   req_be = '0;
  logic [18:0]  tlb_ppn = '0;
  logic         req_ready, rsp_valid, rsp_abort;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid, mem_req_write;
  logic         mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0]  mem_req_addr;
  logic [255:0] mem_req_wdata, mem_rsp_rdata = '0;

  int n_checks = 0, n_fails = 0;
  int n_fill = 0, n_wb = 0;
  logic [31:0]  last_fill_addr = '0, last_wb_addr = '0;
  logic [255:0] last_wb_line = '0;
  bit done = 1'b0;

  logic [255:0] mem_lines [int unsigned];
  logic [31:0]  gold      [int unsigned];

  always #(CLK_PERIOD / 2) clk = ~clk;

  vipt_dcache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata), .req_be(req_be),
    .tlb_valid(tlb_valid), .tlb_ppn(tlb_ppn),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  function automatic logic [31:0] seed_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0000 ^ {a[15:0], 16'h0};
  endfunction

  function automatic logic [255:0] line_of(input logic [31:0] la);
    logic [255:0] r;
    if (mem_lines.exists(la)) return mem_lines[la];
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = seed_word(la + 32'(i * 4));
    return r;
  endfunction

  function automatic logic [31:0] gold_rd(input logic [31:0] pa);
    return gold.exists(pa) ? gold[pa] : seed_word(pa);
  endfunction

  function automatic logic [31:0] phys(input logic [18:0] ppn, input logic [31:0] va);
    return {ppn, va[12:2], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: stalls every request for two cycles
  initial begin : responder
    int stall = 0;
    logic [31:0]  first_addr = '0, cap_addr = '0;
    logic         cap_write = 1'b0;
    logic [255:0] cap_wdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        stall = 0;
        if (cap_write) begin
          mem_lines[cap_addr] = cap_wdata;
          n_wb++;
          last_wb_addr = cap_addr;
          last_wb_line = cap_wdata;
        end else begin
          mem_rsp_rdata = line_of(cap_addr);
          mem_rsp_valid = 1'b1;
          n_fill++;
          last_fill_addr = cap_addr;
        end
      end else if (mem_req_valid && rst_n) begin
        if (stall == 0) first_addr = mem_req_addr;
        else chk(mem_req_addr == first_addr, "R11", "held memory address", mem_req_addr, first_addr);
        stall++;
        if (stall == 2) begin
          mem_req_ready = 1'b1;
          cap_addr  = mem_req_addr;
          cap_write = mem_req_write;
          cap_wdata = mem_req_wdata;
        end
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] va, input logic [18:0] ppn,
                        input bit tv, input logic [31:0] wd, input logic [3:0] be,
                        output logic [31:0] rd, output bit ab);
    bit busy_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd;
    req_be = be; tlb_valid = tv; tlb_ppn = ppn;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; tlb_valid = 1'b0;
    chk(!req_ready, "R10", "ready low after accept", 32'(req_ready), 32'd0);
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    chk(busy_ok, "R10", "ready low until response", 32'(busy_ok), 32'd1);
    rd = rsp_rdata; ab = rsp_abort;
    @(negedge clk);
    chk(!rsp_valid, "R12", "response is one cycle", 32'(rsp_valid), 32'd0);
    if (wr && !ab) begin
      logic [31:0] pa, v;
      pa = phys(ppn, va);
      v  = gold_rd(pa);
      for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = wd[b*8 +: 8];
      gold[pa] = v;
    end
  endtask

  task automatic rd_expect(input logic [31:0] va, input logic [18:0] ppn, input string req,
                           input int fill_delta);
    logic [31:0] d; bit ab; int f0;
    f0 = n_fill;
    access(1'b0, va, ppn, 1'b1, '0, '0, d, ab);
    chk(d == gold_rd(phys(ppn, va)), req, "read data", d, gold_rd(phys(ppn, va)));
    chk(n_fill - f0 == fill_delta, req, "refill count", 32'(n_fill - f0), 32'(fill_delta));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
    chk(!rsp_valid, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(!mem_req_valid, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_read_miss_hit;
    rd_expect(32'h0000_1040, 19'h100, "R2", 1);
    chk(last_fill_addr == 32'h0020_1040, "R2", "refill line address", last_fill_addr, 32'h0020_1040);
    rd_expect(32'h0000_1044, 19'h100, "R2", 0);
  endtask

  task automatic t_alias;
    rd_expect(32'h0004_5044, 19'h100, "R3", 0);
  endtask

  task automatic t_tag_mismatch;
    rd_expect(32'h0000_1040, 19'h200, "R4", 1);
    chk(last_fill_addr == 32'h0040_1040, "R4", "refill line address", last_fill_addr, 32'h0040_1040);
  endtask

  task automatic t_write_hit;
    logic [31:0] d; bit ab; int f0, w0;
    f0 = n_fill; w0 = n_wb;
    access(1'b1, 32'h0000_1048, 19'h100, 1'b1, 32'hDEAD_BEEF, 4'b0101, d, ab);
    chk((n_fill == f0) && (n_wb == w0), "R5", "no traffic on write hit", 32'(n_fill - f0), 32'd0);
    rd_expect(32'h0000_1048, 19'h100, "R5", 0);
  endtask

  task automatic t_write_miss;
    logic [31:0] d; bit ab; int f0;
    f0 = n_fill;
    access(1'b1, 32'h0000_2080, 19'h300, 1'b1, 32'hCAFE_F00D, 4'b1111, d, ab);
    chk(n_fill - f0 == 1, "R6", "write miss refills", 32'(n_fill - f0), 32'd1);
    rd_expect(32'h0000_2080, 19'h300, "R6", 0);
  endtask

  task automatic t_lru;
    logic [31:0] va;
    va = 32'h0000_0100;
    for (int p = 1; p <= 4; p++) rd_expect(va, 19'(32'h400 + p), "R7", 1);
    rd_expect(va, 19'h401, "R7", 0);
    rd_expect(va, 19'h405, "R7", 1);
    rd_expect(va, 19'h401, "R7", 0);
    rd_expect(va, 19'h402, "R7", 1);
    rd_expect(va, 19'h404, "R7", 0);
  endtask

  task automatic t_dirty_evict;
    logic [31:0] d; bit ab; int w0;
    access(1'b1, 32'h0000_0204, 19'h501, 1'b1, 32'h1234_5678, 4'b1111, d, ab);
    for (int p = 2; p <= 4; p++) rd_expect(32'h0000_0200, 19'(32'h500 + p), "R8", 1);
    w0 = n_wb;
    rd_expect(32'h0000_0200, 19'h505, "R8", 1);
    chk(n_wb - w0 == 1, "R8", "dirty victim written back", 32'(n_wb - w0), 32'd1);
    chk(last_wb_addr == 32'h00A0_2200, "R8", "write-back address", last_wb_addr, 32'h00A0_2200);
    chk(last_wb_line[63:32] == 32'h1234_5678, "R8", "write-back data", last_wb_line[63:32], 32'h1234_5678);
    w0 = n_wb;
    rd_expect(32'h0000_0204, 19'h501, "R8", 1);
    chk(n_wb == w0, "R8", "clean victim not written", 32'(n_wb - w0), 32'd0);
  endtask

  task automatic t_abort;
    logic [31:0] d; bit ab; int f0, w0;
    rd_expect(32'h0000_0300, 19'h601, "R9", 1);
    f0 = n_fill; w0 = n_wb;
    access(1'b1, 32'h0000_0300, 19'h601, 1'b0, 32'hFFFF_FFFF, 4'b1111, d, ab);
    chk(ab == 1'b1, "R9", "abort flag", 32'(ab), 32'd1);
    chk((n_fill == f0) && (n_wb == w0), "R9", "no traffic on abort", 32'(n_fill - f0 + n_wb - w0), 32'd0);
    rd_expect(32'h0000_0300, 19'h601, "R9", 0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_read_miss_hit();
    t_alias();
    t_tag_mismatch();
    t_write_hit();
    t_write_miss();
    t_lru();
    t_dirty_evict();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule